// File: doc/BRIEF.md
# Keypad Code Lock Controller

This block is a clocked controller for a door lock driven by a ten-key numeric pad. Each key has its own active-high line. The secret is a sequence of digits fixed by a parameter. The operator enters the digits one at a time, in order, and releases the pad fully between digits. When the last digit of the sequence has been accepted, the bolt-release output `z` rises. It stays high until the door-open switch reports that the door has been opened. The controller then falls back to idle and waits for a new entry. Any wrong or ambiguous entry sends the machine back to idle, so a guess has to be restarted from the first digit.

All eleven raw inputs pass through a two-stage synchroniser. A per-line debounce filter follows. A line is only seen to change after it has held its new level for `DB_LEN` consecutive clocks, so contact bounce cannot produce extra presses. The state register counts how many digits have been matched so far. The value `DIGITS` means unlocked. This count is brought out on the `state` pins so that test equipment can watch the progress of an entry.

Top module: `code_lock`

## Requirements
- R1: Key line `key[i]` stands for digit i (0 to 9). The code parameter `CODE` holds one digit per 4-bit nibble, and the first digit to enter is in the most significant nibble (default 20'h31415 means 3,1,4,1,5).
- R2: The `state` output equals the number of code digits matched so far. Each accepted correct digit raises it by exactly one, and it holds between presses.
- R3: `z` is high exactly while `state` equals `DIGITS` (5 by default). It rises on the cycle after the last correct digit is accepted.
- R4: While unlocked, a debounced high on `door` returns `state` to 0 and drops `z`.
- R5: While `rst` is high, the state is 0 and `z` is low. Release of reset leaves the machine idle.
- R6: A press in which more than one key is active counts as a wrong entry and returns `state` to 0.
- R7: A digit is taken only on a press edge, which means going from no key active to some key active. A key added while another is still held is ignored until every key has been released.
- R8: A single wrong key while locked returns `state` to 0, and the whole code must then be re-entered.
- R9: While unlocked, key presses have no effect, and `state` stays at `DIGITS`.
- R10: A change on any input lasting fewer than `DB_LEN` clocks is ignored. A bouncing press that finally settles counts as one press.
- R11: While locked, `door` has no effect on `state`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous active-high reset to idle |
| key | input | 10 | Raw key lines, bit i is digit i, active high |
| door | input | 1 | Raw door-open switch, active high |
| z | output | 1 | Bolt release, high while unlocked |
| state | output | 3 | Count of matched digits, `DIGITS` means unlocked |

## Verification
On every cycle, the checker verifies the following:
- the state moves only up by one or back to zero;
- any advance follows a debounced key vector with exactly one bit set;
- `z` rises only out of the last-but-one count;
- the door switch always clears the unlocked state, and nothing else leaves that state;
- reset forces idle.

Some behaviour can only be shown by the bench's scenarios:
- that the right digit in the right position is required;
- that keys added while another key is held are ignored until release;
- that short glitches and bounce are filtered;
- that the door is ignored while locked.

The bench covers these with directed cases and with seeded random sequences compared against a reference model.

// File: rtl/lock_pkg.sv
package lock_pkg;

  localparam int KEYS    = 10;
  localparam int DIGIT_W = 4;

  typedef enum logic [1:0] {
    PK_NONE   = 2'd0,
    PK_SINGLE = 2'd1,
    PK_MULTI  = 2'd2
  } press_kind_t;

endpackage

// File: rtl/lock_sync.sv
module lock_sync #(
  parameter int W      = 11,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/lock_debounce.sv
module lock_debounce #(
  parameter int W      = 11,
  parameter int DB_LEN = 50000
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] raw,
  output logic [W-1:0] clean
);

  localparam int CNT_W = (DB_LEN > 1) ? $clog2(DB_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DB_LEN - 1);

  for (genvar g = 0; g < W; g++) begin : g_line
    logic [CNT_W-1:0] cnt;
    logic             lvl;

    always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
        cnt <= '0;
        lvl <= 1'b0;
      end else if (raw[g] == lvl) begin
        cnt <= '0;
      end else if (cnt == LAST) begin
        cnt <= '0;
        lvl <= raw[g];
      end else begin
        cnt <= cnt + 1'b1;
      end
    end

    assign clean[g] = lvl;
  end

endmodule

// File: rtl/lock_press.sv
module lock_press
  import lock_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [KEYS-1:0]    keys,
  output press_kind_t        kind,
  output logic [DIGIT_W-1:0] digit
);

  logic armed;
  logic any_key;

  assign any_key = |keys;

  always_ff @(posedge clk or posedge rst) begin
    if (rst)           armed <= 1'b1;
    else if (!any_key) armed <= 1'b1;
    else               armed <= 1'b0;
  end

  always_comb begin
    digit = '0;
    for (int i = KEYS - 1; i >= 0; i--) begin
      if (keys[i]) digit = DIGIT_W'(i);
    end
  end

  always_comb begin
    if (!(armed && any_key))      kind = PK_NONE;
    else if ($countones(keys) == 1) kind = PK_SINGLE;
    else                          kind = PK_MULTI;
  end

endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
  import lock_pkg::*;
#(
  parameter int                     DIGITS  = 5,
  parameter logic [4*DIGITS-1:0]    CODE    = 20'h31415,
  parameter int                     STATE_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  press_kind_t        kind,
  input  logic [DIGIT_W-1:0] digit,
  input  logic               door_open,
  output logic [STATE_W-1:0] state,
  output logic               z
);

  localparam logic [STATE_W-1:0] IDLE = '0;
  localparam logic [STATE_W-1:0] OPEN = STATE_W'(DIGITS);

  logic [STATE_W-1:0] nxt;
  logic [DIGIT_W-1:0] want;

  always_comb begin
    want = '0;
    for (int i = 0; i < DIGITS; i++) begin
      if (i == int'(state)) want = CODE[DIGIT_W*(DIGITS-1-i) +: DIGIT_W];
    end
  end

  always_comb begin
    nxt = state;
    if (state == OPEN) begin
      if (door_open) nxt = IDLE;
    end else begin
      case (kind)
        PK_SINGLE: nxt = (digit == want) ? state + 1'b1 : IDLE;
        PK_MULTI:  nxt = IDLE;
        default:   nxt = state;
      endcase
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) state <= IDLE;
    else     state <= nxt;
  end

  assign z = (state == OPEN);

endmodule

// File: rtl/code_lock.sv
module code_lock
  import lock_pkg::*;
#(
  parameter int                  DIGITS = 5,
  parameter logic [4*DIGITS-1:0] CODE   = 20'h31415,
  parameter int                  DB_LEN = 50000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [KEYS-1:0] key,
  input  logic            door,
  output logic            z,
  output logic [((DIGITS + 1 > 8) ? $clog2(DIGITS + 1) : 3) - 1:0] state
);

  localparam int STATE_W = (DIGITS + 1 > 8) ? $clog2(DIGITS + 1) : 3;
  localparam int LINES   = KEYS + 1;

  logic [LINES-1:0]   raw_sync;
  logic [LINES-1:0]   lines_db;
  logic [KEYS-1:0]    keys_db;
  logic               door_db;
  press_kind_t        kind;
  logic [DIGIT_W-1:0] digit;

  lock_sync #(.W(LINES), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .d({door, key}), .q(raw_sync)
  );

  lock_debounce #(.W(LINES), .DB_LEN(DB_LEN)) u_db (
    .clk(clk), .rst(rst), .raw(raw_sync), .clean(lines_db)
  );

  assign keys_db = lines_db[KEYS-1:0];
  assign door_db = lines_db[KEYS];

  lock_press u_press (
    .clk(clk), .rst(rst), .keys(keys_db), .kind(kind), .digit(digit)
  );

  lock_fsm #(.DIGITS(DIGITS), .CODE(CODE), .STATE_W(STATE_W)) u_fsm (
    .clk(clk), .rst(rst), .kind(kind), .digit(digit),
    .door_open(door_db), .state(state), .z(z)
  );

endmodule

// File: rtl/lock_checker.sv
module lock_checker #(
  parameter int DIGITS  = 5,
  parameter int STATE_W = 3,
  parameter int KEYS    = 10
) (
  input logic               clk,
  input logic               rst,
  input logic               z,
  input logic [STATE_W-1:0] state,
  input logic [KEYS-1:0]    keys_db,
  input logic               door_db
);

  localparam logic [STATE_W-1:0] OPEN = STATE_W'(DIGITS);
  localparam logic [STATE_W-1:0] LAST = STATE_W'(DIGITS - 1);

  // R2: only step up by one or fall back to idle
  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (state != $past(state)) |-> (state == '0 || state == $past(state) + 1'b1));

  // R3: unlock only out of the last-but-one count
  p_z_rise_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(z) |-> ($past(state) == LAST));

  // R4: door clears the unlocked state
  p_door_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (state == OPEN && door_db) |=> (state == '0 && !z));

  // R5: reset holds idle
  p_reset_idle_r5: assert property (@(posedge clk)
    rst |=> (state == '0 && !z));

  // R6: any advance comes from a single active key
  p_single_key_r6: assert property (@(posedge clk) disable iff (rst)
    (state != '0 && state != $past(state)) |-> ($countones($past(keys_db)) == 1));

  // R9: unlocked state holds without the door
  p_open_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (state == OPEN && !door_db) |=> (state == OPEN));

endmodule

bind code_lock lock_checker #(
  .DIGITS(DIGITS), .STATE_W(STATE_W), .KEYS(lock_pkg::KEYS)
) u_lock_chk (
  .clk(clk), .rst(rst), .z(z), .state(state),
  .keys_db(keys_db), .door_db(door_db)
);

// File: tb/test_code_lock.sv
module test_code_lock;

  localparam int          DIGITS = 5;
  localparam logic [19:0] CODE   = 20'h31415;
  localparam int          DB     = 8;
  localparam int          HOLD   = DB + 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] key = '0;
  logic       door = 1'b0;
  logic       z;
  logic [2:0] state;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int model  = 0;

  always #10 clk = ~clk;

  code_lock #(.DIGITS(DIGITS), .CODE(CODE), .DB_LEN(DB)) i_code_lock (
    .clk(clk), .rst(rst), .key(key), .door(door), .z(z), .state(state)
  );

  function automatic int code_digit(int idx);
    return int'((CODE >> (4 * (DIGITS - 1 - idx))) & 20'hF);
  endfunction

  function automatic int next_after_press(int s, logic [9:0] v);
    int d;
    if (s == DIGITS) return s;
    if ($countones(v) != 1) return 0;
    d = 0;
    for (int i = 0; i < 10; i++) if (v[i]) d = i;
    return (d == code_digit(s)) ? s + 1 : 0;
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic press(logic [9:0] v);
    key = v;
    tick(HOLD);
    key = '0;
    tick(HOLD);
    model = next_after_press(model, v);
  endtask

  task automatic open_door();
    door = 1'b1;
    tick(HOLD);
    door = 1'b0;
    tick(HOLD);
    if (model == DIGITS) model = 0;
  endtask

  task automatic enter_code();
    for (int i = 0; i < DIGITS; i++) press(10'b1 << code_digit(i));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int r;
    logic [9:0] v;
    tick(4);
    // R5: reset state
    check("R5 state in reset", int'(state), 0);
    check("R5 z in reset", int'(z), 0);
    rst = 1'b0;
    tick(4);
    check("R5 idle after reset", int'(state), 0);

    // R1 R2: ordered correct digits advance by one
    for (int i = 0; i < DIGITS; i++) begin
      press(10'b1 << code_digit(i));
      check("R2 count after correct digit", int'(state), i + 1);
    end
    // R3: unlocked
    check("R3 z after full code", int'(z), 1);
    // R9: keys ignored while open
    press(10'b1 << 7);
    check("R9 state with key while open", int'(state), DIGITS);
    check("R9 z with key while open", int'(z), 1);
    // R4: door returns to idle
    open_door();
    check("R4 state after door", int'(state), 0);
    check("R4 z after door", int'(z), 0);

    // R11: door ignored when locked
    press(10'b1 << code_digit(0));
    open_door();
    check("R11 door while locked", int'(state), 1);

    // R8: wrong digit mid-sequence
    press(10'b1 << code_digit(1));
    press(10'b1 << 9);
    check("R8 wrong digit resets", int'(state), 0);
    press(10'b1 << code_digit(1));
    check("R8 restart needed", int'(state), 0);

    // R6: two keys at once
    press(10'b1 << code_digit(0));
    press((10'b1 << code_digit(1)) | 10'b1);
    check("R6 multi key resets", int'(state), 0);

    // R7: key added while held is ignored
    key = 10'b1 << code_digit(0);
    tick(HOLD);
    key = key | (10'b1 << code_digit(1));
    tick(HOLD);
    check("R7 added key ignored", int'(state), 1);
    key = '0;
    tick(HOLD);
    model = 1;
    press(10'b1 << code_digit(1));
    check("R7 accepted after release", int'(state), 2);

    // R10: short glitches ignored, bouncing press counts once
    for (int b = 0; b < 4; b++) begin
      key = 10'b1 << code_digit(2);
      tick(DB / 2);
      key = '0;
      tick(DB / 2);
    end
    tick(HOLD);
    check("R10 glitches ignored", int'(state), 2);
    for (int b = 0; b < 3; b++) begin
      key = 10'b1 << code_digit(2);
      tick(DB / 2);
      key = '0;
      tick(DB / 2);
    end
    press(10'b1 << code_digit(2));
    check("R10 bounce counted once", int'(state), 3);

    // R5: reset mid-entry
    rst = 1'b1;
    tick(2);
    rst = 1'b0;
    tick(2);
    model = 0;
    check("R5 reset mid entry", int'(state), 0);

    // R1 R2 R3 R6 R8: seeded random mix
    void'($urandom(32'd20240611));
    for (int it = 0; it < 80; it++) begin
      r = int'($urandom_range(99));
      if (model == DIGITS && r < 40) begin
        open_door();
        check("R4 random door", int'(state), model);
      end else begin
        if (r < 65 && model < DIGITS) v = 10'b1 << code_digit(model);
        else if (r < 88) v = 10'b1 << $urandom_range(9);
        else v = 10'(($urandom_range(1022) + 1) | (1 << $urandom_range(9)));
        press(v);
        check("R2 random press", int'(state), model);
        check("R3 random z", int'(z), (model == DIGITS) ? 1 : 0);
      end
    end

    finish_run();
  end

endmodule